// File: doc/BRIEF.md
# Calibrated RSSI Averaging Engine

This block turns raw logarithmic signal-strength codes from a shared ADC into averaged linear-power readings for two RF channels. Each incoming code selects one entry of a 128-entry linearisation table. The entry is the anti-logged and corrected power value for that code. It is multiplied by a host-set gain, summed over a power-of-two window of samples and divided by the window length with a right shift.

A measurement starts with a one-cycle start strobe. The first window of accepted samples belongs to channel 1 and the second window belongs to channel 2. The channel 1 average is held back internally. Both published results change on the same clock edge, one cycle after the product of the last channel 2 sample is registered, and a one-cycle valid pulse marks that edge.

The host can overwrite any table entry through an address/data write strobe. Until it does so, each entry holds a computed default: an exponential ramp in which entry i equals 2 to the power of floor(i/8).

Top module: `rssi_avg_engine`

## Requirements
- R1: After reset, `busy` and `res_valid` are 0, both results are 0, and table entry i holds 1 << (i >> 3) (i in 0..127).
- R2: The table index is bits [9:3] of the 10-bit `smp_code`. Bits [2:0] have no effect on the result.
- R3: A cycle with `tbl_we` high replaces entry `tbl_addr` with `tbl_wdata`. Every sample accepted after that edge uses the new value.
- R4: Each accepted sample contributes floor(entry * `rssi_gain` / 16), so a gain of 16 is unity.
- R5: The window is 2^`win_log` samples, with `win_log` captured at the start strobe. Each result is floor(sum of contributions / 2^`win_log`).
- R6: `meas_start` while idle raises `busy` on the next cycle. The first window of samples with `smp_valid` goes to channel 1 and the next window goes to channel 2, after which `busy` falls. Samples offered while idle are ignored.
- R7: `res_ch1` and `res_ch2` change only on the cycle in which `res_valid` is high. `res_valid` is high for exactly one cycle, one cycle after `busy` falls. Between the two windows, the previous pair stays visible.
- R8: `meas_start` while `busy` is high has no effect on the sequence or on the results.
- R9: With all entries at 65535, a gain of 255 and a window of 128, the result is exact: 1044464.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | 7 | Table entry to write |
| tbl_wdata | input | 16 | New entry value |
| rssi_gain | input | 8 | Gain, 4 fractional bits |
| win_log | input | 3 | Log2 of window length |
| meas_start | input | 1 | Start a two-channel measurement |
| smp_valid | input | 1 | ADC sample present |
| smp_code | input | 10 | ADC sample code |
| busy | output | 1 | Measurement in progress |
| res_valid | output | 1 | One-cycle pulse on result update |
| res_ch1 | output | 20 | Channel 1 average |
| res_ch2 | output | 20 | Channel 2 average |

## Verification
Two-channel measurements are swept over every table index with the default table, with varying low code bits. This separates correct indexing and default contents from off-by-one slicing. The sweep is repeated with a host-loaded pseudo-random table under gains of 1, 16, 37 and 255, which exposes errors in the write path and in gain scaling and truncation. Every window length from 1 to 128 is run with ramping codes, which tests the shift and the window count. A saturated run with maximum entry, gain and window probes accumulator width. Idle samples, a start strobe during a measurement and the gap between the two windows check that nothing leaks into the results early.

// File: rtl/rssi_pkg.sv
package rssi_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_CH1  = 2'd1,
    SEQ_CH2  = 2'd2
  } seq_state_e;

  // Exponential default ramp: value doubles every (depth / entry_w) entries.
  function automatic logic [31:0] default_entry(input int idx, input int idx_w, input int entry_w);
    int sh;
    sh = (idx * entry_w) >> idx_w;
    return 32'(1) << sh;
  endfunction

endpackage

// File: rtl/rssi_cal_table.sv
module rssi_cal_table #(
  parameter int IDX_W   = 7,
  parameter int ENTRY_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ENTRY_W-1:0] wr_data,
  input  logic [IDX_W-1:0]   rd_idx,
  output logic [ENTRY_W-1:0] rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [ENTRY_W-1:0] ent_q [DEPTH];
  logic [ENTRY_W-1:0] ent_d [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    localparam logic [ENTRY_W-1:0] DEF = ENTRY_W'(rssi_pkg::default_entry(g, IDX_W, ENTRY_W));
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));

    always_comb begin
      ent_d[g] = ent_q[g];
      if (hit) ent_d[g] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q[g] <= DEF;
      else if (hit) ent_q[g] <= ent_d[g];
    end
  end

  assign rd_data = ent_q[rd_idx];

endmodule

// File: rtl/rssi_seq.sv
module rssi_seq #(
  parameter int WLOG_MAX = 7,
  parameter int WLOG_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              smp_valid,
  input  logic [WLOG_W-1:0] win_log,
  output logic              accept,
  output logic              last,
  output logic              ch_sel,
  output logic              busy,
  output logic [WLOG_W-1:0] win_cur
);
  import rssi_pkg::*;

  localparam int CNT_W = WLOG_MAX + 1;

  seq_state_e        st_q, st_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WLOG_W-1:0] win_q, win_d;
  logic [CNT_W-1:0]  len_m1;

  assign len_m1 = (CNT_W'(1) << win_q) - CNT_W'(1);
  assign busy   = (st_q != SEQ_IDLE);
  assign accept = busy && smp_valid;
  assign last   = accept && (cnt_q == len_m1);
  assign ch_sel = (st_q == SEQ_CH2);
  assign win_cur = win_q;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    win_d = win_q;
    unique case (st_q)
      SEQ_IDLE: begin
        if (start) begin
          st_d  = SEQ_CH1;
          cnt_d = '0;
          win_d = win_log;
        end
      end
      SEQ_CH1: begin
        if (accept) begin
          if (last) begin
            st_d  = SEQ_CH2;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      SEQ_CH2: begin
        if (accept) begin
          if (last) begin
            st_d  = SEQ_IDLE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + CNT_W'(1);
          end
        end
      end
      default: st_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      cnt_q <= '0;
      win_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      win_q <= win_d;
    end
  end

endmodule

// File: rtl/rssi_gain_stage.sv
module rssi_gain_stage #(
  parameter int ENTRY_W   = 16,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 4,
  parameter int PROD_W    = ENTRY_W + GAIN_W - GAIN_FRAC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic               in_last,
  input  logic               in_ch,
  input  logic [ENTRY_W-1:0] entry,
  input  logic [GAIN_W-1:0]  gain,
  output logic               out_valid,
  output logic               out_last,
  output logic               out_ch,
  output logic [PROD_W-1:0]  out_prod
);
  localparam int FULL_W = ENTRY_W + GAIN_W;

  logic [FULL_W-1:0] full;
  logic [PROD_W-1:0] prod_d;
  logic              vld_q, last_q, ch_q;
  logic [PROD_W-1:0] prod_q;

  assign full   = FULL_W'(entry) * FULL_W'(gain);
  assign prod_d = PROD_W'(full >> GAIN_FRAC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      last_q <= 1'b0;
      ch_q   <= 1'b0;
    end else begin
      vld_q  <= in_valid;
      last_q <= in_valid && in_last;
      ch_q   <= in_ch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prod_q <= '0;
    else if (in_valid) prod_q <= prod_d;
  end

  assign out_valid = vld_q;
  assign out_last  = last_q;
  assign out_ch    = ch_q;
  assign out_prod  = prod_q;

endmodule

// File: rtl/rssi_window_acc.sv
module rssi_window_acc #(
  parameter int PROD_W = 20,
  parameter int ACC_W  = 27,
  parameter int WLOG_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              p_valid,
  input  logic              p_last,
  input  logic              p_ch,
  input  logic [PROD_W-1:0] p_prod,
  input  logic [WLOG_W-1:0] win_sh,
  output logic              res_valid,
  output logic [PROD_W-1:0] res1,
  output logic [PROD_W-1:0] res2
);
  logic [ACC_W-1:0]  acc_q, acc_d, sum;
  logic [PROD_W-1:0] hold_q, hold_d;
  logic [PROD_W-1:0] r1_q, r1_d, r2_q, r2_d;
  logic              rv_d, rv_q;
  logic [PROD_W-1:0] avg;

  assign sum = acc_q + ACC_W'(p_prod);
  assign avg = PROD_W'(sum >> win_sh);

  always_comb begin
    acc_d  = acc_q;
    hold_d = hold_q;
    r1_d   = r1_q;
    r2_d   = r2_q;
    rv_d   = 1'b0;
    if (p_valid) begin
      if (p_last) begin
        acc_d = '0;
        if (!p_ch) begin
          hold_d = avg;
        end else begin
          r1_d = hold_q;
          r2_d = avg;
          rv_d = 1'b1;
        end
      end else begin
        acc_d = sum;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      hold_q <= '0;
      r1_q   <= '0;
      r2_q   <= '0;
      rv_q   <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      hold_q <= hold_d;
      r1_q   <= r1_d;
      r2_q   <= r2_d;
      rv_q   <= rv_d;
    end
  end

  assign res_valid = rv_q;
  assign res1      = r1_q;
  assign res2      = r2_q;

endmodule

// File: rtl/rssi_avg_engine.sv
module rssi_avg_engine #(
  parameter int SMP_W     = 10,
  parameter int IDX_W     = 7,
  parameter int ENTRY_W   = 16,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 4,
  parameter int WLOG_MAX  = 7,
  parameter int WLOG_W    = $clog2(WLOG_MAX + 1),
  parameter int PROD_W    = ENTRY_W + GAIN_W - GAIN_FRAC
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tbl_we,
  input  logic [IDX_W-1:0]   tbl_addr,
  input  logic [ENTRY_W-1:0] tbl_wdata,
  input  logic [GAIN_W-1:0]  rssi_gain,
  input  logic [WLOG_W-1:0]  win_log,
  input  logic               meas_start,
  input  logic               smp_valid,
  input  logic [SMP_W-1:0]   smp_code,
  output logic               busy,
  output logic               res_valid,
  output logic [PROD_W-1:0]  res_ch1,
  output logic [PROD_W-1:0]  res_ch2
);
  localparam int ACC_W = PROD_W + WLOG_MAX;

  logic [IDX_W-1:0]   smp_idx;
  logic               unused_low_bits;
  logic [ENTRY_W-1:0] lin_val;
  logic               acc_en, acc_last, acc_ch;
  logic [WLOG_W-1:0]  win_cur;
  logic               g_vld, g_last, g_ch;
  logic [PROD_W-1:0]  g_prod;

  assign smp_idx         = smp_code[SMP_W-1 -: IDX_W];
  assign unused_low_bits = ^smp_code[SMP_W-IDX_W-1:0];

  rssi_cal_table #(.IDX_W(IDX_W), .ENTRY_W(ENTRY_W)) u_tbl (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tbl_we), .wr_idx(tbl_addr), .wr_data(tbl_wdata),
    .rd_idx(smp_idx), .rd_data(lin_val)
  );

  rssi_seq #(.WLOG_MAX(WLOG_MAX), .WLOG_W(WLOG_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .start(meas_start), .smp_valid(smp_valid), .win_log(win_log),
    .accept(acc_en), .last(acc_last), .ch_sel(acc_ch),
    .busy(busy), .win_cur(win_cur)
  );

  rssi_gain_stage #(.ENTRY_W(ENTRY_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC),
                    .PROD_W(PROD_W)) u_gain (
    .clk(clk), .rst_n(rst_n),
    .in_valid(acc_en), .in_last(acc_last), .in_ch(acc_ch),
    .entry(lin_val), .gain(rssi_gain),
    .out_valid(g_vld), .out_last(g_last), .out_ch(g_ch), .out_prod(g_prod)
  );

  rssi_window_acc #(.PROD_W(PROD_W), .ACC_W(ACC_W), .WLOG_W(WLOG_W)) u_acc (
    .clk(clk), .rst_n(rst_n),
    .p_valid(g_vld), .p_last(g_last), .p_ch(g_ch), .p_prod(g_prod),
    .win_sh(win_cur),
    .res_valid(res_valid), .res1(res_ch1), .res2(res_ch2)
  );

endmodule

// File: rtl/rssi_avg_checker.sv
module rssi_avg_checker #(
  parameter int ENTRY_W   = 16,
  parameter int GAIN_W    = 8,
  parameter int GAIN_FRAC = 4,
  parameter int PROD_W    = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              meas_start,
  input logic              busy,
  input logic              res_valid,
  input logic [PROD_W-1:0] res_ch1,
  input logic [PROD_W-1:0] res_ch2
);
  localparam longint PEAK = ((64'(1) << ENTRY_W) - 1) * ((64'(1) << GAIN_W) - 1) >> GAIN_FRAC;

  // R7: single-cycle update pulse
  p_pulse_one_r7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R7: results frozen outside the update cycle
  p_hold_pair_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> ($stable(res_ch1) && $stable(res_ch2)));

  // R6: idle start begins a measurement
  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_start && !busy) |=> busy);

  // R7: update follows end of second window
  p_done_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |=> res_valid);

  // R9: averages never exceed the largest single contribution
  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (64'(res_ch1) <= PEAK && 64'(res_ch2) <= PEAK));

endmodule

bind rssi_avg_engine rssi_avg_checker #(
  .ENTRY_W(ENTRY_W), .GAIN_W(GAIN_W), .GAIN_FRAC(GAIN_FRAC), .PROD_W(PROD_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .meas_start(meas_start), .busy(busy),
  .res_valid(res_valid), .res_ch1(res_ch1), .res_ch2(res_ch2)
);

// File: tb/sim_rssi_avg_engine.sv
`timescale 1ns/1ps
module sim_rssi_avg_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tbl_we = 1'b0;
  logic [6:0]  tbl_addr = '0;
  logic [15:0] tbl_wdata = '0;
  logic [7:0]  rssi_gain = 8'd16;
  logic [2:0]  win_log = '0;
  logic        meas_start = 1'b0;
  logic        smp_valid = 1'b0;
  logic [9:0]  smp_code = '0;
  logic        busy, res_valid;
  logic [19:0] res_ch1, res_ch2;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  longint model_tbl [128];

  always #5 clk = ~clk;

  rssi_avg_engine u0 (
    .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .rssi_gain(rssi_gain), .win_log(win_log),
    .meas_start(meas_start), .smp_valid(smp_valid), .smp_code(smp_code),
    .busy(busy), .res_valid(res_valid), .res_ch1(res_ch1), .res_ch2(res_ch2)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint contrib(input int code, input int g);
    return (model_tbl[(code >> 3) & 127] * g) >> 4;
  endfunction

  task automatic tbl_write(input int a, input int d);
    @(negedge clk);
    tbl_we = 1'b1; tbl_addr = 7'(a); tbl_wdata = 16'(d);
    @(negedge clk);
    tbl_we = 1'b0;
    model_tbl[a] = longint'(d & 16'hFFFF);
  endtask

  // Two-channel measurement; codes are base + k*step modulo 1024
  task automatic run_pair(input int wl, input int g, input int b1, input int s1,
                          input int b2, input int s2, input bit mid_start);
    int n;
    longint s_a, s_b, e1, e2, p1, p2;
    n = 1 << wl;
    s_a = 0; s_b = 0;
    for (int k = 0; k < n; k++) s_a += contrib((b1 + k * s1) & 1023, g);
    for (int k = 0; k < n; k++) s_b += contrib((b2 + k * s2) & 1023, g);
    e1 = s_a >> wl;
    e2 = s_b >> wl;
    @(negedge clk);
    p1 = res_ch1; p2 = res_ch2;
    rssi_gain = 8'(g); win_log = 3'(wl); meas_start = 1'b1;
    @(negedge clk);
    meas_start = 1'b0;
    chk(busy == 1'b1, "R6 busy after start", busy, 1);
    for (int k = 0; k < n; k++) begin
      smp_valid = 1'b1; smp_code = 10'((b1 + k * s1) & 1023);
      meas_start = mid_start && (k == 0); // R8: start while busy
      win_log = mid_start ? 3'(7 - wl) : 3'(wl);
      @(negedge clk);
    end
    smp_valid = 1'b0; meas_start = 1'b0;
    @(negedge clk);
    // R7: between windows the old pair is still shown
    chk(res_ch1 == 20'(p1) && res_ch2 == 20'(p2) && !res_valid, "R7 pair held between windows",
        res_ch1, p1);
    chk(busy == 1'b1, "R8 still busy after first window", busy, 1);
    for (int k = 0; k < n; k++) begin
      smp_valid = 1'b1; smp_code = 10'((b2 + k * s2) & 1023);
      @(negedge clk);
    end
    smp_valid = 1'b0;
    @(negedge clk);
    chk(res_valid == 1'b1, "R7 valid pulse", res_valid, 1);
    chk(64'(res_ch1) == e1, "R5 ch1 average", res_ch1, e1);
    chk(64'(res_ch2) == e2, "R5 ch2 average", res_ch2, e2);
    chk(busy == 1'b0, "R6 idle after second window", busy, 0);
    @(negedge clk);
    chk(res_valid == 1'b0, "R7 pulse one cycle", res_valid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 128; i++) model_tbl[i] = longint'(1) << (i >> 3);
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0 && res_valid == 1'b0, "R1 reset flags", {busy, res_valid}, 0);
    chk(res_ch1 == 0 && res_ch2 == 0, "R1 reset results", res_ch1 | res_ch2, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1/R2: default table over every index, low code bits varying
    for (int i = 0; i < 64; i++)
      run_pair(0, 16, (i << 3) | (i & 7), 0, ((127 - i) << 3) | ((i * 3) & 7), 0, 1'b0);

    // R6: samples while idle are ignored
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      smp_valid = 1'b1; smp_code = 10'(1023 - k * 50);
    end
    @(negedge clk);
    smp_valid = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && res_valid == 1'b0, "R6 idle samples ignored", busy, 0);
    run_pair(1, 16, 40, 8, 200, 16, 1'b0);

    // R3: host-loaded table
    for (int i = 0; i < 128; i++) tbl_write(i, (i * 517 + 33 + (i * i * 91)) & 16'hFFFF);
    // R4: gains 1, 16, 37, 255
    for (int gi = 0; gi < 4; gi++) begin
      int g;
      g = (gi == 0) ? 1 : (gi == 1) ? 16 : (gi == 2) ? 37 : 255;
      for (int i = 0; i < 64; i++)
        run_pair(0, g, (i << 3) | 5, 0, (127 - i) << 3, 0, 1'b0);
    end

    // R5: every window length, R8: start during measurement
    for (int wl = 0; wl < 8; wl++) begin
      run_pair(wl, 23, 5 + wl * 37, 61, 900, 133, 1'b0);
      run_pair(wl, 200, 17 * wl, 9, 3, 251, 1'b1);
    end

    // R3: single rewrite affects later samples
    tbl_write(64, 1234);
    run_pair(0, 16, 64 << 3, 0, (64 << 3) | 7, 0, 1'b0);

    // R9: saturated accumulation
    tbl_write(127, 16'hFFFF);
    run_pair(7, 255, 1023, 0, 1016, 0, 1'b0);
    chk(res_ch1 == 20'd1044464 && res_ch2 == 20'd1044464, "R9 full-scale result", res_ch2, 1044464);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule